// File: doc/BRIEF.md
# Indexed Audio Codec Host Register Interface

This block is the host-side control logic of an audio codec. The host reaches it through four byte-wide ports selected by a 2-bit port address. The first port is an index port. It selects one of sixteen 8-bit indirect registers and also holds a mode-change-enable bit and a transfer-request-disable bit. The second port reads and writes the indirect register that the index selects. The third port is a status register. The fourth port carries polled sample data.

The block enforces three access rules:
- A busy period follows reset, and software power-down also counts as busy.
- The format and interface-configuration registers are locked unless mode-change-enable is set.
- The two stream-enable bits are free of that lock.

Playback and capture appear only as request/acknowledge handshakes paced by a sample-period tick. A programmable countdown raises an interrupt flag, and that flag can hold DMA requests back. The block drives a registered left/right sample to the converters. That sample is forced to silence by mode-change-enable or by a per-channel mute bit.

Top module: `codec_hostif`

## Requirements
- R1: Port encoding is 0 = index, 1 = indirect data, 2 = status, 3 = polled data. Reads are side-effect free, and `host_rdata` shows the selected port one clock after `host_addr` is presented. The index port reads {busy[7], mce[6], trd[5], addr[4:0]}, and writes to it set bits 6:0. After reset the index port reads 0x80 for INIT_CYCLES clocks, then reads 0x00.
- R2: While busy (init period or `pwr_down` high), writes to the data port are ignored and the data port reads 0x80.
- R3: A data-port write stores into indirect register addr[3:0], and a read returns it; all indirect registers reset to 0. With addr[4] set, data writes are ignored and reads return 0x00.
- R4: Writes to register 8 (format), and to bits 7:2 of register 9 (configuration), are discarded while mce is 0 and accepted while mce is 1.
- R5: Bits 1:0 of register 9 (bit 0 playback enable, bit 1 capture enable) are writable whatever mce is.
- R6: While mce is 1, `dac_left` and `dac_right` read 0 from the following clock on.
- R7: Bit 7 of register 6 mutes `dac_left`, and bit 7 of register 7 mutes `dac_right`. An unmuted channel outputs the last supplied playback sample.
- R8: The countdown is {reg14, reg15}. It is reloaded while playback is disabled and counts down once per tick while playback is enabled. When a tick finds it at zero, it reloads and the interrupt bit (status bit 0) sets, so a value N gives an interrupt on every (N+1)th tick.
- R9: Any write to the status port clears the interrupt bit and the sample-error bit, whatever the data.
- R10: A tick with playback enabled sets the sample-error bit (status bit 4) when no sample has been supplied since the previous tick.
- R11: When trd is 1 and the interrupt bit is 1, `play_drq` and `cap_drq` are held low. With trd at 0 they follow the pending requests.
- R12: The status port reads {0[7], capture L/R[6], capture ready[5], sample error[4], 0[3], playback L/R[2], playback ready[1], interrupt[0]}. The ready bits set on a tick while the stream is enabled and clear when a sample moves. The L/R bits toggle on each transfer while register 8 bit 4 (stereo) is set, and stay 0 otherwise.
- R13: A polled-port write supplies a playback sample, in the same way as `play_ack`. A polled-port read returns the last byte captured on `cap_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Host port select |
| host_wr | input | 1 | Host write strobe, one clock per write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| pwr_down | input | 1 | Software power-down, makes the block busy |
| sample_tick | input | 1 | One-clock pulse per sample period |
| play_drq | output | 1 | Playback DMA request |
| play_ack | input | 1 | Playback sample delivered |
| play_data | input | 8 | Playback sample with `play_ack` |
| cap_drq | output | 1 | Capture DMA request |
| cap_ack | input | 1 | Capture sample taken |
| cap_data | input | 8 | Capture sample with `cap_ack` |
| dac_left | output | 8 | Left converter sample |
| dac_right | output | 8 | Right converter sample |

## Verification
The bench writes the locked registers with the lock both closed and open, and writes register 9 with mixed bits. A design that applied the lock to the whole byte, or to none of it, would read back a wrong value. It counts ticks to the first interrupt, so a countdown that is off by one, or that fails to reload, shows up on the wrong tick. It lets a tick pass with no sample supplied to catch a missing sample error, and toggles trd while the interrupt flag is up to catch a request gate that ignores either signal. It also writes during the busy period and at index addresses 16 and above, where a leaky design would corrupt a stored register.

// File: rtl/codec_pkg.sv
package codec_pkg;

  typedef enum logic [1:0] {
    PORT_INDEX = 2'd0,
    PORT_DATA  = 2'd1,
    PORT_STAT  = 2'd2,
    PORT_PIO   = 2'd3
  } port_e;

  localparam int REG_W    = 8;
  localparam int NUM_REGS = 16;
  localparam int IDX_AW   = $clog2(NUM_REGS);

  localparam int VOL_L_IDX = 6;
  localparam int VOL_R_IDX = 7;
  localparam int FMT_IDX   = 8;
  localparam int CFG_IDX   = 9;
  localparam int CNT_H_IDX = 14;
  localparam int CNT_L_IDX = 15;

  localparam int MUTE_BIT   = 7;
  localparam int STEREO_BIT = 4;
  localparam int PEN_BIT    = 0;
  localparam int CEN_BIT    = 1;

  localparam logic [REG_W-1:0] BUSY_READ = 8'h80;

  // bits an indirect register accepts while the mode lock is closed
  function automatic logic [REG_W-1:0] open_bits(input logic [IDX_AW-1:0] idx);
    if (idx == IDX_AW'(FMT_IDX))      open_bits = '0;
    else if (idx == IDX_AW'(CFG_IDX)) open_bits = REG_W'((1 << (CEN_BIT + 1)) - 1);
    else                              open_bits = '1;
  endfunction

endpackage

// File: rtl/codec_init_timer.sv
module codec_init_timer #(
  parameter int INIT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  output logic init_busy
);
  localparam int CW = $clog2(INIT_CYCLES + 1);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)                 remain_q <= CW'(INIT_CYCLES);
    else if (remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  assign init_busy = (remain_q != '0);
endmodule

// File: rtl/codec_regbank.sv
module codec_regbank
  import codec_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  parameter int W    = REG_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [$clog2(NREG)-1:0]   wr_idx,
  input  logic [W-1:0]              wr_data,
  input  logic                      mce,
  output logic [NREG-1:0][W-1:0]    regs_q
);
  localparam int AW = $clog2(NREG);

  logic [W-1:0] wmask;

  always_comb begin
    wmask = mce ? '1 : W'(open_bits(IDX_AW'(wr_idx)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wr_idx] <= (regs_q[wr_idx] & ~wmask) | (wr_data & wmask);
    end
  end

  logic unused_aw;
  assign unused_aw = ^AW;
endmodule

// File: rtl/codec_stream.sv
module codec_stream #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pen,
  input  logic             cen,
  input  logic             stereo,
  input  logic             trd,
  input  logic [CNT_W-1:0] reload,
  input  logic             play_supply,
  input  logic             cap_take,
  input  logic             stat_clr,
  output logic             play_pend,
  output logic             cap_pend,
  output logic             int_flag,
  output logic             ser_flag,
  output logic             play_lr,
  output logic             cap_lr,
  output logic             play_drq,
  output logic             cap_drq
);
  logic [CNT_W-1:0] count_q;
  logic             expire;
  logic             starved;

  assign expire  = pen && tick && (count_q == '0);
  assign starved = pen && tick && play_pend && !play_supply;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      int_flag  <= 1'b0;
      ser_flag  <= 1'b0;
      play_pend <= 1'b0;
      cap_pend  <= 1'b0;
      play_lr   <= 1'b0;
      cap_lr    <= 1'b0;
    end else begin
      if (!pen)      count_q <= reload;
      else if (tick) count_q <= (count_q == '0) ? reload : count_q - 1'b1;

      if (expire)        int_flag <= 1'b1;
      else if (stat_clr) int_flag <= 1'b0;

      if (starved)       ser_flag <= 1'b1;
      else if (stat_clr) ser_flag <= 1'b0;

      if (!pen)             play_pend <= 1'b0;
      else if (tick)        play_pend <= 1'b1;
      else if (play_supply) play_pend <= 1'b0;

      if (!cen)          cap_pend <= 1'b0;
      else if (tick)     cap_pend <= 1'b1;
      else if (cap_take) cap_pend <= 1'b0;

      if (!stereo)          play_lr <= 1'b0;
      else if (play_supply) play_lr <= ~play_lr;

      if (!stereo)       cap_lr <= 1'b0;
      else if (cap_take) cap_lr <= ~cap_lr;
    end
  end

  logic hold_req;
  assign hold_req = trd && int_flag;
  assign play_drq = play_pend && !hold_req;
  assign cap_drq  = cap_pend && !hold_req;
endmodule

// File: rtl/codec_hostif.sv
module codec_hostif
  import codec_pkg::*;
#(
  parameter int INIT_CYCLES = 64,
  parameter int CNT_W       = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] host_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       pwr_down,
  input  logic       sample_tick,
  output logic       play_drq,
  input  logic       play_ack,
  input  logic [7:0] play_data,
  output logic       cap_drq,
  input  logic       cap_ack,
  input  logic [7:0] cap_data,
  output logic [7:0] dac_left,
  output logic [7:0] dac_right
);
  localparam int AF_W = IDX_AW + 1;

  port_e port_sel;
  assign port_sel = port_e'(host_addr);

  logic init_busy, busy;
  codec_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst(rst), .init_busy(init_busy)
  );
  assign busy = init_busy || pwr_down;

  // index port state
  logic            mce_q, trd_q;
  logic [AF_W-1:0] addr_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      mce_q  <= 1'b0;
      trd_q  <= 1'b0;
      addr_q <= '0;
    end else if (host_wr && port_sel == PORT_INDEX) begin
      mce_q  <= host_wdata[6];
      trd_q  <= host_wdata[5];
      addr_q <= host_wdata[AF_W-1:0];
    end
  end

  logic in_range;
  assign in_range = !addr_q[AF_W-1];

  logic data_wr;
  assign data_wr = host_wr && port_sel == PORT_DATA && !busy && in_range;

  logic [NUM_REGS-1:0][REG_W-1:0] regs;
  codec_regbank #(.NREG(NUM_REGS), .W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(data_wr), .wr_idx(addr_q[IDX_AW-1:0]),
    .wr_data(host_wdata), .mce(mce_q), .regs_q(regs)
  );

  logic pio_wr, stat_wr, supply;
  assign pio_wr  = host_wr && port_sel == PORT_PIO;
  assign stat_wr = host_wr && port_sel == PORT_STAT;
  assign supply  = pio_wr || play_ack;

  logic play_pend, cap_pend, int_flag, ser_flag, play_lr, cap_lr;
  codec_stream #(.CNT_W(CNT_W)) u_stream (
    .clk(clk), .rst(rst), .tick(sample_tick),
    .pen(regs[CFG_IDX][PEN_BIT]), .cen(regs[CFG_IDX][CEN_BIT]),
    .stereo(regs[FMT_IDX][STEREO_BIT]), .trd(trd_q),
    .reload(CNT_W'({regs[CNT_H_IDX], regs[CNT_L_IDX]})),
    .play_supply(supply), .cap_take(cap_ack), .stat_clr(stat_wr),
    .play_pend(play_pend), .cap_pend(cap_pend), .int_flag(int_flag),
    .ser_flag(ser_flag), .play_lr(play_lr), .cap_lr(cap_lr),
    .play_drq(play_drq), .cap_drq(cap_drq)
  );

  // sample path to the converters
  logic [7:0] sample_q, cap_hold_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q   <= '0;
      cap_hold_q <= '0;
      dac_left   <= '0;
      dac_right  <= '0;
    end else begin
      if (pio_wr)        sample_q <= host_wdata;
      else if (play_ack) sample_q <= play_data;
      if (cap_ack) cap_hold_q <= cap_data;
      dac_left  <= (mce_q || regs[VOL_L_IDX][MUTE_BIT]) ? '0 : sample_q;
      dac_right <= (mce_q || regs[VOL_R_IDX][MUTE_BIT]) ? '0 : sample_q;
    end
  end

  // registered read mux
  logic [7:0] status_byte, rd_next;
  assign status_byte = {1'b0, cap_lr, cap_pend, ser_flag,
                        1'b0, play_lr, play_pend, int_flag};

  always_comb begin
    unique case (port_sel)
      PORT_INDEX: rd_next = {busy, mce_q, trd_q, 5'(addr_q)};
      PORT_DATA:  rd_next = busy ? BUSY_READ :
                            (in_range ? regs[addr_q[IDX_AW-1:0]] : 8'h00);
      PORT_STAT:  rd_next = status_byte;
      default:    rd_next = cap_hold_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_next;
  end
endmodule

// File: rtl/codec_hostif_chk.sv
module codec_hostif_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] host_addr,
  input logic [7:0] host_rdata,
  input logic       busy,
  input logic       mce,
  input logic [7:0] fmt,
  input logic [7:0] dac_left,
  input logic [7:0] dac_right,
  input logic       sample_tick,
  input logic       int_flag,
  input logic       ser_flag
);
  AST_BUSY_READ: assert property (@(posedge clk) disable iff (rst)
    (host_addr == 2'd1 && busy) |=> host_rdata == 8'h80); // R2
  AST_FMT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !mce |=> $stable(fmt)); // R4
  AST_MCE_SILENT: assert property (@(posedge clk) disable iff (rst)
    mce |=> (dac_left == 8'h00 && dac_right == 8'h00)); // R6
  AST_INT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(int_flag) |-> $past(sample_tick)); // R8
  AST_SER_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_flag) |-> $past(sample_tick)); // R10
endmodule

bind codec_hostif codec_hostif_chk u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_rdata(host_rdata),
  .busy(busy), .mce(mce_q), .fmt(regs[8]), .dac_left(dac_left),
  .dac_right(dac_right), .sample_tick(sample_tick),
  .int_flag(int_flag), .ser_flag(ser_flag)
);

// File: tb/codec_hostif_bench.sv
`timescale 1ns/1ps
module codec_hostif_bench;
  localparam int INIT = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] host_addr = 2'd0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       pwr_down = 1'b0;
  logic       sample_tick = 1'b0;
  logic       play_drq, cap_drq;
  logic       play_ack = 1'b0, cap_ack = 1'b0;
  logic [7:0] play_data = 8'h00, cap_data = 8'h00;
  logic [7:0] dac_left, dac_right;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  codec_hostif #(.INIT_CYCLES(INIT)) u_codec_hostif (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pwr_down(pwr_down),
    .sample_tick(sample_tick), .play_drq(play_drq), .play_ack(play_ack),
    .play_data(play_data), .cap_drq(cap_drq), .cap_ack(cap_ack),
    .cap_data(cap_data), .dac_left(dac_left), .dac_right(dac_right)
  );

  // {mce, index, write data, expected readback}
  localparam logic [20:0] VEC [11] = '{
    {1'b0, 4'd0,  8'hA5, 8'hA5},
    {1'b0, 4'd6,  8'h80, 8'h80},
    {1'b0, 4'd8,  8'h55, 8'h00},
    {1'b1, 4'd8,  8'h11, 8'h11},
    {1'b0, 4'd9,  8'hFE, 8'h02},
    {1'b1, 4'd9,  8'hA4, 8'hA4},
    {1'b0, 4'd9,  8'h03, 8'hA7},
    {1'b1, 4'd9,  8'h00, 8'h00},
    {1'b0, 4'd15, 8'hC3, 8'hC3},
    {1'b0, 4'd6,  8'h00, 8'h00},
    {1'b1, 4'd8,  8'h00, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic tick();
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
  endtask

  task automatic pack(input logic [7:0] d);
    @(negedge clk); play_ack = 1'b1; play_data = d;
    @(negedge clk); play_ack = 1'b0;
  endtask

  task automatic set_reg(input logic [3:0] idx, input logic [7:0] d);
    wr(2'd0, {4'b0000, idx});
    wr(2'd1, d);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset and busy period
    rd(2'd0, r); check("R1 index busy after reset", r, 8'h80);
    rd(2'd1, r); check("R2 data reads 0x80 while busy", r, 8'h80);
    wr(2'd1, 8'h5A);
    repeat (INIT + 4) @(negedge clk);
    rd(2'd0, r); check("R1 index after init", r, 8'h00);
    rd(2'd1, r); check("R2 busy write ignored", r, 8'h00);

    // table walk: indirect writes under and outside the lock
    for (int i = 0; i < 11; i++) begin
      wr(2'd0, {1'b0, VEC[i][20], 2'b00, VEC[i][19:16]});
      wr(2'd1, VEC[i][15:8]);
      wr(2'd0, {4'b0000, VEC[i][19:16]});
      rd(2'd1, r);
      if (VEC[i][19:16] == 4'd8 || VEC[i][19:16] == 4'd9)
        check("R4/R5 locked register", r, VEC[i][7:0]);
      else
        check("R3 indirect readback", r, VEC[i][7:0]);
    end

    // countdown, interrupt, sample error, request gate
    set_reg(4'd14, 8'h00);
    set_reg(4'd15, 8'h02);
    wr(2'd0, 8'h29);
    wr(2'd1, 8'h01);
    tick();
    check("R11 request with INT clear", {7'd0, play_drq}, 8'h01);
    rd(2'd2, r); check("R12 playback ready", r, 8'h02);
    pack(8'h11); tick(); pack(8'h22); tick();
    rd(2'd2, r); check("R8 interrupt on third tick", r, 8'h03);
    check("R11 TRD holds request", {7'd0, play_drq}, 8'h00);
    wr(2'd2, 8'h5A);
    rd(2'd2, r); check("R9 status write clears INT", r, 8'h02);
    check("R11 request resumes", {7'd0, play_drq}, 8'h01);
    tick();
    rd(2'd2, r); check("R10 starved tick", r, 8'h12);
    wr(2'd2, 8'hFF);
    rd(2'd2, r); check("R9 status write clears SER", r, 8'h02);
    wr(2'd0, 8'h09);
    tick(); tick();
    rd(2'd2, r); check("R8 reload period", r, 8'h13);
    check("R11 TRD clear passes request", {7'd0, play_drq}, 8'h01);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h3C);
    rd(2'd2, r); check("R13 polled write supplies sample", r, 8'h00);

    // converter outputs
    @(negedge clk);
    check("R7 left unmuted", dac_left, 8'h3C);
    check("R7 right unmuted", dac_right, 8'h3C);
    wr(2'd0, 8'h49);
    @(negedge clk);
    check("R6 MCE silences left", dac_left, 8'h00);
    check("R6 MCE silences right", dac_right, 8'h00);
    set_reg(4'd6, 8'h80);
    @(negedge clk);
    check("R7 left muted", dac_left, 8'h00);
    check("R7 right still plays", dac_right, 8'h3C);
    set_reg(4'd6, 8'h00);

    // stereo ordering and capture
    wr(2'd0, 8'h48); wr(2'd1, 8'h10);
    set_reg(4'd9, 8'h03);
    wr(2'd3, 8'h44);
    rd(2'd2, r); check("R12 playback L/R toggles", r, 8'h04);
    tick();
    rd(2'd2, r); check("R12 both ready", r, 8'h26);
    check("R12 capture request", {7'd0, cap_drq}, 8'h01);
    @(negedge clk); cap_ack = 1'b1; cap_data = 8'h77;
    @(negedge clk); cap_ack = 1'b0;
    rd(2'd2, r); check("R12 capture L/R toggles", r, 8'h46);
    rd(2'd3, r); check("R13 polled read", r, 8'h77);
    set_reg(4'd9, 8'h00);

    // power-down
    pwr_down = 1'b1;
    rd(2'd1, r); check("R2 power-down data read", r, 8'h80);
    rd(2'd0, r); check("R1 power-down busy bit", r, 8'h89);
    wr(2'd1, 8'hEE);
    pwr_down = 1'b0;
    rd(2'd1, r); check("R2 power-down write ignored", r, 8'h00);

    // upper index range
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h99);
    rd(2'd1, r); check("R3 high index reads zero", r, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd1, r); check("R3 register 0 untouched", r, 8'hA5);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule